// File: doc/BRIEF.md
# Fixed-Priority Packet Memory Arbiter

This block decides which of four agents may use a shared packet buffer memory on each memory cycle. The agents are, from highest to lowest rank, a refresh engine inside the block, a pointer-mover stage, a network-side FIFO stage and a host-side stage. The host-side port is shared by two virtual sources, the host itself and a management processor, which are multiplexed onto one physical request. Each external agent raises a level request and keeps it until it sees its grant. A grant stays high for every memory cycle of the transfer. Keeping a request high after the last grant cycle asks for another transfer.

A transfer is a single longword of one or two memory cycles, or a 32-byte burst of consecutive cycles. Once a transfer has started, nothing interrupts it. New decisions are made only at a transfer boundary, so a steady request stream runs back to back with no idle cycle. Two rules keep the lower ranks moving. First, the pointer-mover stage always moves a single longword and must then sit out two cycles. Second, a host request that has been waiting longer than a programmable limit is lifted above the FIFO stage for one grant. The refresh engine counts a programmable number of cycles between refresh requests and holds the memory for a fixed number of cycles per refresh.

Top module: `pmem_arbiter`

## Requirements
- R1: When several requests compete at a decision point, the winner is the first eligible one in this order: refresh, pointer mover, FIFO stage, host stage.
- R2: A refresh request becomes pending every `refreshInterval` cycles, counted from the release of reset. Each refresh holds `refGnt` for REF_CYCLES (default 4) consecutive cycles with `memCmd` = 2'b01. Refresh outranks every other request.
- R3: The kind inputs set the transfer length. Kind 2'b00 is one cycle and kind 2'b01 is two cycles, both with `memCmd` = 2'b10. Kind 2'b10 or 2'b11 is a burst of BURST_BEATS cycles (default 8) with `memCmd` = 2'b11.
- R4: A transfer that has started is never cut short. A request that is still held at the end of a transfer's last cycle starts the next transfer in the following cycle, with no idle cycle between them.
- R5: A pointer-mover grant always lasts one cycle with `memCmd` = 2'b10. The two cycles that follow it never carry a pointer-mover grant. During that gap, lower requesters are served.
- R6: Once a host request has waited `hostAgeLimit` cycles without a grant, the host ranks above the FIFO stage at the next decision point. Refresh and the pointer mover still rank above it. While the host is below its limit, a continuously requesting FIFO stage keeps the host waiting.
- R7: At most one grant is high in any cycle. `memBusy` is high exactly when a grant is high. `memCmd` is 2'b00 exactly when no grant is high.
- R8: `memHostMgr` shows the value `hostIsMgr` had at the decision point that started a host transfer. It holds that value for the whole transfer, even if `hostIsMgr` changes.
- R9: During and directly after reset, all grants and `memBusy` are low and `memCmd` is 2'b00.
- R10: A request that is present before a decision edge while the memory is idle gets its grant in the cycle right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| refreshInterval | input | CNT_W | Number of cycles between refresh requests |
| hostAgeLimit | input | AGE_W | Number of waiting cycles after which the host is promoted |
| moverReq | input | 1 | Pointer-mover request (always one longword) |
| fifoReq | input | 1 | FIFO-stage request |
| fifoKind | input | 2 | FIFO-stage transfer kind |
| hostReq | input | 1 | Host-side request |
| hostKind | input | 2 | Host-side transfer kind |
| hostIsMgr | input | 1 | Host-side virtual source: 1 = management processor, 0 = host |
| refGnt | output | 1 | Refresh grant |
| moverGnt | output | 1 | Pointer-mover grant |
| fifoGnt | output | 1 | FIFO-stage grant |
| hostGnt | output | 1 | Host-side grant |
| memCmd | output | 2 | Memory command for this cycle: 00 idle, 01 refresh, 10 longword, 11 burst |
| memHostMgr | output | 1 | Virtual source of the host transfer in progress |
| memBusy | output | 1 | Memory cycle in use |

## Verification
The assertions check the grant rules on every cycle. These are: at most one grant, agreement between the grants, `memCmd` and `memBusy`, the two-cycle pointer-mover gap, bursts running to their full length, the single-cycle length of each pointer-mover grant, and a ceiling on how long a host request can wait. Other behaviours depend on a particular stimulus, so only the bench's scenarios show them. These are the exact order in which competing requests are served, the refresh period and its length, the exact number of FIFO grants before the host is promoted, the kind-to-length encoding, and the host-side source being held through a transfer.

// File: rtl/pmem_arb_pkg.sv
package pmem_arb_pkg;

  typedef enum logic [1:0] {
    SRC_REF   = 2'd0,
    SRC_MOVER = 2'd1,
    SRC_FIFO  = 2'd2,
    SRC_HOST  = 2'd3
  } src_e;

  typedef enum logic [1:0] {
    CMD_IDLE    = 2'b00,
    CMD_REFRESH = 2'b01,
    CMD_WORD    = 2'b10,
    CMD_BURST   = 2'b11
  } cmd_e;

  // strobes from the control to the datapath
  typedef struct packed {
    logic start;    // begin a transfer at this edge
    src_e owner;    // winner
    cmd_e cmd;      // command of the transfer
    logic pair;     // longword occupies two cycles
    logic hostMgr;  // virtual source of a host transfer
  } arb_strobe_t;

endpackage

// File: rtl/pmem_arb_ctrl.sv
module pmem_arb_ctrl
  import pmem_arb_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int AGE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] refreshInterval,
  input  logic [AGE_W-1:0] hostAgeLimit,
  input  logic             moverReq,
  input  logic             fifoReq,
  input  logic [1:0]       fifoKind,
  input  logic             hostReq,
  input  logic [1:0]       hostKind,
  input  logic             hostIsMgr,
  input  logic             atBoundary,
  output arb_strobe_t      strobe
);

  localparam logic [1:0] MOVER_GAP = 2'd2;
  localparam logic [AGE_W-1:0] AGE_MAX = {AGE_W{1'b1}};

  logic [CNT_W-1:0] refCnt;
  logic             refPending;
  logic             refHit;
  logic [1:0]       moverHold;
  logic [AGE_W-1:0] hostWait;
  logic             hostAged;
  logic             moverOk;

  assign refHit   = (refCnt >= refreshInterval - CNT_W'(1));
  assign hostAged = (hostWait >= hostAgeLimit);
  assign moverOk  = moverReq && (moverHold == 2'd0);

  // refresh interval timer
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      refCnt     <= '0;
      refPending <= 1'b0;
    end else begin
      refCnt <= refHit ? '0 : refCnt + CNT_W'(1);
      if (refHit)
        refPending <= 1'b1;
      else if (strobe.start && strobe.owner == SRC_REF)
        refPending <= 1'b0;
    end
  end

  // winner selection at a transfer boundary
  always_comb begin
    strobe         = '0;
    strobe.owner   = SRC_REF;
    strobe.cmd     = CMD_IDLE;
    strobe.hostMgr = hostIsMgr;
    if (atBoundary) begin
      if (refPending) begin
        strobe.start = 1'b1;
        strobe.owner = SRC_REF;
        strobe.cmd   = CMD_REFRESH;
      end else if (moverOk) begin
        strobe.start = 1'b1;
        strobe.owner = SRC_MOVER;
        strobe.cmd   = CMD_WORD;
      end else if (hostReq && hostAged) begin
        strobe.start = 1'b1;
        strobe.owner = SRC_HOST;
        strobe.cmd   = hostKind[1] ? CMD_BURST : CMD_WORD;
        strobe.pair  = (hostKind == 2'b01);
      end else if (fifoReq) begin
        strobe.start = 1'b1;
        strobe.owner = SRC_FIFO;
        strobe.cmd   = fifoKind[1] ? CMD_BURST : CMD_WORD;
        strobe.pair  = (fifoKind == 2'b01);
      end else if (hostReq) begin
        strobe.start = 1'b1;
        strobe.owner = SRC_HOST;
        strobe.cmd   = hostKind[1] ? CMD_BURST : CMD_WORD;
        strobe.pair  = (hostKind == 2'b01);
      end
    end
  end

  // pointer-mover cool-down and host waiting age
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      moverHold <= '0;
      hostWait  <= '0;
    end else begin
      if (strobe.start && strobe.owner == SRC_MOVER)
        moverHold <= MOVER_GAP;
      else if (moverHold != 2'd0)
        moverHold <= moverHold - 2'd1;

      if (strobe.start && strobe.owner == SRC_HOST)
        hostWait <= '0;
      else if (!hostReq)
        hostWait <= '0;
      else if (hostWait != AGE_MAX)
        hostWait <= hostWait + AGE_W'(1);
    end
  end

endmodule

// File: rtl/pmem_arb_dp.sv
module pmem_arb_dp
  import pmem_arb_pkg::*;
#(
  parameter int REF_CYCLES  = 4,
  parameter int BURST_BEATS = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  arb_strobe_t strobe,
  output logic        atBoundary,
  output logic [3:0]  gntVec,
  output logic [1:0]  memCmd,
  output logic        memHostMgr,
  output logic        memBusy
);

  localparam int MAX_LEN = (REF_CYCLES > BURST_BEATS) ? REF_CYCLES : BURST_BEATS;
  localparam int LEN_W   = $clog2(MAX_LEN + 1);

  logic [LEN_W-1:0] remaining;
  logic [LEN_W-1:0] newLen;
  src_e             ownerReg;
  cmd_e             cmdReg;
  logic             mgrReg;

  always_comb begin
    unique case (strobe.cmd)
      CMD_REFRESH: newLen = LEN_W'(REF_CYCLES);
      CMD_BURST:   newLen = LEN_W'(BURST_BEATS);
      CMD_WORD:    newLen = strobe.pair ? LEN_W'(2) : LEN_W'(1);
      default:     newLen = '0;
    endcase
  end

  assign atBoundary = (remaining <= LEN_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remaining <= '0;
      ownerReg  <= SRC_REF;
      cmdReg    <= CMD_IDLE;
      mgrReg    <= 1'b0;
    end else if (strobe.start) begin
      remaining <= newLen;
      ownerReg  <= strobe.owner;
      cmdReg    <= strobe.cmd;
      if (strobe.owner == SRC_HOST)
        mgrReg <= strobe.hostMgr;
    end else if (remaining != '0) begin
      remaining <= remaining - LEN_W'(1);
    end
  end

  assign memBusy = (remaining != '0);

  for (genvar g = 0; g < 4; g++) begin : g_gnt
    assign gntVec[g] = memBusy && (ownerReg == src_e'(g));
  end

  assign memCmd     = memBusy ? cmdReg : CMD_IDLE;
  assign memHostMgr = mgrReg;

endmodule

// File: rtl/pmem_arbiter.sv
module pmem_arbiter
  import pmem_arb_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int AGE_W       = 8,
  parameter int REF_CYCLES  = 4,
  parameter int BURST_BEATS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] refreshInterval,
  input  logic [AGE_W-1:0] hostAgeLimit,
  input  logic             moverReq,
  input  logic             fifoReq,
  input  logic [1:0]       fifoKind,
  input  logic             hostReq,
  input  logic [1:0]       hostKind,
  input  logic             hostIsMgr,
  output logic             refGnt,
  output logic             moverGnt,
  output logic             fifoGnt,
  output logic             hostGnt,
  output logic [1:0]       memCmd,
  output logic             memHostMgr,
  output logic             memBusy
);

  arb_strobe_t strobe;
  logic        atBoundary;
  logic [3:0]  gntVec;

  pmem_arb_ctrl #(.CNT_W(CNT_W), .AGE_W(AGE_W)) u_ctrl (
    .clk             (clk),
    .rst_n           (rst_n),
    .refreshInterval (refreshInterval),
    .hostAgeLimit    (hostAgeLimit),
    .moverReq        (moverReq),
    .fifoReq         (fifoReq),
    .fifoKind        (fifoKind),
    .hostReq         (hostReq),
    .hostKind        (hostKind),
    .hostIsMgr       (hostIsMgr),
    .atBoundary      (atBoundary),
    .strobe          (strobe)
  );

  pmem_arb_dp #(.REF_CYCLES(REF_CYCLES), .BURST_BEATS(BURST_BEATS)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .atBoundary (atBoundary),
    .gntVec     (gntVec),
    .memCmd     (memCmd),
    .memHostMgr (memHostMgr),
    .memBusy    (memBusy)
  );

  assign refGnt   = gntVec[SRC_REF];
  assign moverGnt = gntVec[SRC_MOVER];
  assign fifoGnt  = gntVec[SRC_FIFO];
  assign hostGnt  = gntVec[SRC_HOST];

endmodule

// File: rtl/pmem_arb_checker.sv
module pmem_arb_checker #(
  parameter int AGE_W       = 8,
  parameter int REF_CYCLES  = 4,
  parameter int BURST_BEATS = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [AGE_W-1:0] hostAgeLimit,
  input logic             hostReq,
  input logic             refGnt,
  input logic             moverGnt,
  input logic             fifoGnt,
  input logic             hostGnt,
  input logic [1:0]       memCmd,
  input logic             memBusy
);

  localparam int POS_W  = $clog2(BURST_BEATS + 1);
  localparam int WAIT_W = AGE_W + 8;

  logic [3:0]        grants;
  logic [POS_W-1:0]  burstPos;
  logic [WAIT_W-1:0] hostStall;
  logic [WAIT_W-1:0] stallBound;

  assign grants     = {hostGnt, fifoGnt, moverGnt, refGnt};
  assign stallBound = WAIT_W'(hostAgeLimit) + WAIT_W'(BURST_BEATS) + WAIT_W'(2 * REF_CYCLES) + WAIT_W'(4);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      burstPos  <= '0;
      hostStall <= '0;
    end else begin
      if (memCmd == 2'b11)
        burstPos <= (burstPos == POS_W'(BURST_BEATS - 1)) ? '0 : burstPos + POS_W'(1);
      else
        burstPos <= '0;
      if (hostReq && !hostGnt)
        hostStall <= hostStall + WAIT_W'(1);
      else
        hostStall <= '0;
    end
  end

  // R7: never two grants at once
  p_one_grant_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grants));

  // R7: busy and command agree with the grants
  p_busy_agrees_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (memBusy == (grants != 4'b0)) && ((memCmd == 2'b00) == (grants == 4'b0)));

  // R5: a pointer-mover grant is single-cycle and followed by two clear cycles
  p_mover_gap1_r5: assert property (@(posedge clk) disable iff (!rst_n)
    moverGnt |=> !moverGnt);
  p_mover_gap2_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(moverGnt, 2) |-> !moverGnt);
  p_mover_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
    moverGnt |-> memCmd == 2'b10);

  // R4: a burst ends or changes owner only after its full length
  p_burst_whole_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(memCmd) == 2'b11 && (memCmd != 2'b11 || grants != $past(grants)))
      |-> burstPos == '0);

  // R6: a waiting host request is served within a bounded time
  p_host_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hostStall <= stallBound);

endmodule

bind pmem_arbiter pmem_arb_checker #(
  .AGE_W(AGE_W), .REF_CYCLES(REF_CYCLES), .BURST_BEATS(BURST_BEATS)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .hostAgeLimit (hostAgeLimit),
  .hostReq      (hostReq),
  .refGnt       (refGnt),
  .moverGnt     (moverGnt),
  .fifoGnt      (fifoGnt),
  .hostGnt      (hostGnt),
  .memCmd       (memCmd),
  .memBusy      (memBusy)
);

// File: tb/pmem_arbiter_bench.sv
module pmem_arbiter_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] refreshInterval = 16'd1000;
  logic [7:0]  hostAgeLimit = 8'd200;
  logic        moverReq = 1'b0;
  logic        fifoReq = 1'b0;
  logic [1:0]  fifoKind = 2'b00;
  logic        hostReq = 1'b0;
  logic [1:0]  hostKind = 2'b00;
  logic        hostIsMgr = 1'b0;
  logic        refGnt, moverGnt, fifoGnt, hostGnt;
  logic [1:0]  memCmd;
  logic        memHostMgr, memBusy;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pmem_arbiter u_pmem_arbiter (
    .clk(clk), .rst_n(rst_n), .refreshInterval(refreshInterval),
    .hostAgeLimit(hostAgeLimit), .moverReq(moverReq), .fifoReq(fifoReq),
    .fifoKind(fifoKind), .hostReq(hostReq), .hostKind(hostKind),
    .hostIsMgr(hostIsMgr), .refGnt(refGnt), .moverGnt(moverGnt),
    .fifoGnt(fifoGnt), .hostGnt(hostGnt), .memCmd(memCmd),
    .memHostMgr(memHostMgr), .memBusy(memBusy)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int gnts();
    return {hostGnt, fifoGnt, moverGnt, refGnt};
  endfunction

  task automatic doReset(input int interval, input int age);
    rst_n = 1'b0;
    moverReq = 0; fifoReq = 0; hostReq = 0;
    fifoKind = 0; hostKind = 0; hostIsMgr = 0;
    refreshInterval = 16'(interval);
    hostAgeLimit = 8'(age);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // R9: reset state
  task automatic t_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R9", "grants in reset", gnts(), 0);
    check("R9", "cmd in reset", memCmd, 0);
    doReset(1000, 200);
    @(negedge clk);
    check("R9", "grants after reset", gnts(), 0);
    check("R9", "busy after reset", memBusy, 0);
  endtask

  // R3 R4 R10: single-cycle longwords, back to back
  task automatic t_word();
    doReset(1000, 200);
    fifoReq = 1; fifoKind = 2'b00;
    for (int i = 1; i <= 3; i++) begin
      @(negedge clk);
      check("R10", "fifo grant back to back", fifoGnt, 1);
      check("R3", "longword cmd", memCmd, 2);
    end
    fifoReq = 0;
    @(negedge clk);
    check("R4", "no grant after request drops", gnts(), 0);
  endtask

  // R3 R8: two-cycle host longword, source held
  task automatic t_pair();
    doReset(1000, 200);
    hostReq = 1; hostKind = 2'b01; hostIsMgr = 1;
    @(negedge clk);
    check("R3", "pair cycle 1 grant", hostGnt, 1);
    check("R8", "manager source", memHostMgr, 1);
    hostReq = 0; hostIsMgr = 0;
    @(negedge clk);
    check("R3", "pair cycle 2 grant", hostGnt, 1);
    check("R8", "source held", memHostMgr, 1);
    @(negedge clk);
    check("R3", "pair ends", memBusy, 0);
  endtask

  // R3 R4: burst not preempted by a higher requester
  task automatic t_burst();
    int cnt = 0;
    doReset(1000, 200);
    fifoReq = 1; fifoKind = 2'b10;
    for (int i = 1; i <= 8; i++) begin
      @(negedge clk);
      if (fifoGnt && memCmd == 2'b11 && !moverGnt) cnt++;
      fifoReq = 0;
      if (i == 2) moverReq = 1;
    end
    check("R3", "burst cycles with burst cmd", cnt, 8);
    @(negedge clk);
    check("R4", "mover after burst", moverGnt, 1);
    check("R4", "cmd after burst", memCmd, 2);
    moverReq = 0;
  endtask

  // R1: priority among mover, fifo, host
  task automatic t_priority();
    doReset(1000, 200);
    moverReq = 1; fifoReq = 1; hostReq = 1;
    @(negedge clk);
    check("R1", "mover first", gnts(), 2);
    moverReq = 0;
    @(negedge clk);
    check("R1", "fifo second", gnts(), 4);
    fifoReq = 0;
    @(negedge clk);
    check("R1", "host third", gnts(), 8);
    hostReq = 0;
    @(negedge clk);
    check("R1", "idle after all", gnts(), 0);
  endtask

  // R5: mover gap filled by fifo
  task automatic t_mover_gap();
    int seq = 0;
    doReset(1000, 200);
    moverReq = 1; fifoReq = 1; fifoKind = 2'b00;
    for (int i = 1; i <= 4; i++) begin
      @(negedge clk);
      seq = seq * 16 + gnts();
    end
    // mover, fifo, fifo, mover
    check("R5", "mover gap sequence", seq, 16'h2442);
    moverReq = 0; fifoReq = 0;
  endtask

  // R2: refresh period, length and rank over the mover
  task automatic t_refresh();
    int first = -1, second = -1, len = 0, moverAt = -1;
    bit prev = 0;
    doReset(20, 200);
    for (int i = 1; i <= 60; i++) begin
      @(negedge clk);
      if (refGnt && !prev) begin
        if (first < 0) first = i;
        else if (second < 0) second = i;
      end
      if (refGnt && second < 0) begin
        len++;
        check("R2", "refresh cmd", memCmd, 1);
      end
      prev = refGnt;
      if (i == 21) check("R2", "refresh beats mover", moverGnt, 0);
      if (moverGnt && moverAt < 0) begin moverAt = i; moverReq = 0; end
      if (i == 20) moverReq = 1;
    end
    check("R2", "first refresh cycle", first, 21);
    check("R2", "refresh length", len, 4);
    check("R2", "refresh period", second - first, 20);
    check("R1", "mover after refresh", moverAt, 25);
  endtask

  // R6: host promotion after waiting
  task automatic t_aging();
    int fifoCnt = 0, hostAt = -1;
    doReset(1000, 10);
    fifoReq = 1; hostReq = 1;
    for (int i = 1; i <= 20 && hostAt < 0; i++) begin
      @(negedge clk);
      if (fifoGnt) fifoCnt++;
      if (hostGnt) begin hostAt = i; hostReq = 0; end
    end
    check("R6", "fifo grants before promotion", fifoCnt, 10);
    check("R6", "host promoted cycle", hostAt, 11);
    @(negedge clk);
    check("R6", "fifo resumes", fifoGnt, 1);
    fifoReq = 0;
    doReset(1000, 200);
    fifoReq = 1; hostReq = 1;
    fifoCnt = 0;
    for (int i = 1; i <= 40; i++) begin
      @(negedge clk);
      if (hostGnt) fifoCnt++;
    end
    check("R6", "host held below limit", fifoCnt, 0);
    fifoReq = 0; hostReq = 0;
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        nChecks++; nFail++;
        $display("FAIL R4 watchdog: actual %0d expected %0d", cyc, 0);
        $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
        $finish;
      end
    end
  end

  initial begin
    t_reset();
    t_word();
    t_pair();
    t_burst();
    t_priority();
    t_mover_gap();
    t_refresh();
    t_aging();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

endmodule